// File: doc/BRIEF.md
# Bitwise Three-Input Truth-Table Unit

This block evaluates an arbitrary three-input Boolean function on every bit position of a word at once. Each bit of the result is looked up in an 8-entry truth table, addressed by the matching bits of three operand words. The third operand is the old value of the destination register, so the unit fits a read-modify-write datapath slot. The table is either an instruction immediate, supplied as two separate fields, or the low byte of a register operand. One truth table therefore stands in for AND, OR, XOR, multiplexing, majority and any other function of three inputs.

An optional lane-masked mode writes only the selected 8-bit lanes of the destination. The other lanes return the old destination value unchanged. The result is registered, and a valid flag follows the input strobe by one clock.

Top module: `tlu_top`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `result` is all zeros until the first accepted input.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low.
- R3: For each bit i, the index is {old_dst[i], src_a[i], src_b[i]}: old_dst gives index bit 2, src_a bit 1 and src_b bit 0. Result bit i is the table bit at that index, counting from the LSB, so index 0 selects table bit 0.
- R4: In immediate mode (`tbl_from_reg`=0), the table is {imm_hi3, imm_lo5}: `imm_lo5` supplies table bits 0 to 4 and `imm_hi3` supplies table bits 5 to 7.
- R5: In register mode (`tbl_from_reg`=1), the table is `tbl_reg[7:0]`. Bits above 7 of `tbl_reg` and both immediate fields have no effect on the result.
- R6: In masked mode (`mask_en`=1), a lane j from 0 to 3 whose `lane_mask[j]` is 1 receives the computed bits 8j to 8j+7.
- R7: In masked mode, a lane whose mask bit is 0 takes the value of `old_dst` for that lane. Every lane at index 4 or above also takes the value of `old_dst`.
- R8: With `mask_en`=0, every bit takes the computed value and `lane_mask` has no effect.
- R9: A table of 0x96 yields old_dst^src_a^src_b, 0xE8 yields the bitwise majority of the three, 0xF0 yields old_dst, 0xCC yields src_a and 0xAA yields src_b.
- R10: `result` stays unchanged in every cycle that follows a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | XLEN | First source word, index bit 1 |
| src_b | input | XLEN | Second source word, index bit 0 |
| old_dst | input | XLEN | Previous destination word, index bit 2 |
| imm_lo5 | input | 5 | Immediate table bits 0 to 4 |
| imm_hi3 | input | 3 | Immediate table bits 5 to 7 |
| tbl_reg | input | XLEN | Register table operand (low byte used) |
| tbl_from_reg | input | 1 | 1 selects the register table |
| mask_en | input | 1 | 1 enables lane masking |
| lane_mask | input | 4 | Per-lane write enables for lanes 0 to 3 |
| out_valid | output | 1 | Result valid |
| result | output | XLEN | New destination word |

## Verification
Table selection and lane merging act in the same cycle. A masked operation that uses a register table is driven with junk in the upper bits of `tbl_reg` and in the immediate fields. The expected word is built from the register byte for the enabled lanes and from `old_dst` for the others, so a wrong table source or a wrong lane choice both show up in one compare. Back-to-back strobes with alternating modes also check that no mode choice leaks from one cycle into the next.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
    localparam int LANE_W     = 8;
    localparam int MASK_LANES = 4;
    localparam int TBL_W      = 8;

    typedef struct packed {
        logic                  from_reg;
        logic                  mask_en;
        logic [MASK_LANES-1:0] lane_mask;
    } tlu_mode_t;
endpackage

// File: rtl/tlu_table_sel.sv
module tlu_table_sel
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [4:0]       imm_lo5,
    input  logic [2:0]       imm_hi3,
    input  logic [XLEN-1:0]  tbl_reg,
    input  logic             from_reg,
    output logic [TBL_W-1:0] table_o
);
    logic [TBL_W-1:0] imm_tbl;

    always_comb begin
        imm_tbl = {imm_hi3, imm_lo5};
        table_o = from_reg ? tbl_reg[TBL_W-1:0] : imm_tbl;
    end
endmodule

// File: rtl/tlu_bit_eval.sv
module tlu_bit_eval
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [TBL_W-1:0] table_i,
    input  logic [XLEN-1:0]  hi_sel,
    input  logic [XLEN-1:0]  mid_sel,
    input  logic [XLEN-1:0]  lo_sel,
    output logic [XLEN-1:0]  bits_o
);
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        logic [2:0] idx;
        assign idx       = {hi_sel[i], mid_sel[i], lo_sel[i]};
        assign bits_o[i] = table_i[idx];
    end
endmodule

// File: rtl/tlu_lane_merge.sv
module tlu_lane_merge
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]       fresh,
    input  logic [XLEN-1:0]       keep,
    input  logic                  mask_en,
    input  logic [MASK_LANES-1:0] lane_mask,
    output logic [XLEN-1:0]       merged
);
    localparam int N_LANES = XLEN / LANE_W;

    for (genvar j = 0; j < N_LANES; j++) begin : g_lane
        logic take_new;
        if (j < MASK_LANES) begin : g_ctl
            assign take_new = !mask_en || lane_mask[j];
        end else begin : g_fix
            assign take_new = !mask_en;
        end
        assign merged[j*LANE_W +: LANE_W] = take_new ? fresh[j*LANE_W +: LANE_W]
                                                     : keep[j*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/tlu_top.sv
module tlu_top
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [XLEN-1:0]       src_a,
    input  logic [XLEN-1:0]       src_b,
    input  logic [XLEN-1:0]       old_dst,
    input  logic [4:0]            imm_lo5,
    input  logic [2:0]            imm_hi3,
    input  logic [XLEN-1:0]       tbl_reg,
    input  logic                  tbl_from_reg,
    input  logic                  mask_en,
    input  logic [MASK_LANES-1:0] lane_mask,
    output logic                  out_valid,
    output logic [XLEN-1:0]       result
);
    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
    } tlu_state_t;

    tlu_mode_t        mode;
    logic [TBL_W-1:0] table_w;
    logic [XLEN-1:0]  eval_w;
    logic [XLEN-1:0]  merged_w;
    tlu_state_t       st_d, st_q;

    assign mode = '{from_reg: tbl_from_reg, mask_en: mask_en, lane_mask: lane_mask};

    tlu_table_sel #(.XLEN(XLEN)) u_tbl (
        .imm_lo5  (imm_lo5),
        .imm_hi3  (imm_hi3),
        .tbl_reg  (tbl_reg),
        .from_reg (mode.from_reg),
        .table_o  (table_w)
    );

    tlu_bit_eval #(.XLEN(XLEN)) u_eval (
        .table_i (table_w),
        .hi_sel  (old_dst),
        .mid_sel (src_a),
        .lo_sel  (src_b),
        .bits_o  (eval_w)
    );

    tlu_lane_merge #(.XLEN(XLEN)) u_merge (
        .fresh     (eval_w),
        .keep      (old_dst),
        .mask_en   (mode.mask_en),
        .lane_mask (mode.lane_mask),
        .merged    (merged_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = merged_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
endmodule

// File: rtl/tlu_checker.sv
module tlu_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [XLEN-1:0] old_dst,
    input logic [4:0]      imm_lo5,
    input logic [2:0]      imm_hi3,
    input logic [XLEN-1:0] tbl_reg,
    input logic            tbl_from_reg,
    input logic            mask_en,
    input logic [3:0]      lane_mask,
    input logic            out_valid,
    input logic [XLEN-1:0] result
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_all_lanes_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && lane_mask == 4'b0000) |=> (result == $past(old_dst)));

    assert_pass_dst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_en && !tbl_from_reg && {imm_hi3, imm_lo5} == 8'hF0)
        |=> (result == $past(old_dst)));

    assert_xor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_en && !tbl_from_reg && {imm_hi3, imm_lo5} == 8'h96)
        |=> (result == ($past(old_dst) ^ $past(src_a) ^ $past(src_b))));

    assert_reg_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_en && tbl_from_reg && tbl_reg[7:0] == 8'h00) |=> (result == '0));
endmodule

bind tlu_top tlu_checker #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .src_a        (src_a),
    .src_b        (src_b),
    .old_dst      (old_dst),
    .imm_lo5      (imm_lo5),
    .imm_hi3      (imm_hi3),
    .tbl_reg      (tbl_reg),
    .tbl_from_reg (tbl_from_reg),
    .mask_en      (mask_en),
    .lane_mask    (lane_mask),
    .out_valid    (out_valid),
    .result       (result)
);

// File: tb/sim_tlu_top.sv
module sim_tlu_top;
    localparam int XLEN = 64;

    typedef struct {
        logic [XLEN-1:0] exp;
        string           tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [XLEN-1:0] src_a = '0, src_b = '0, old_dst = '0, tbl_reg = '0;
    logic [4:0]      imm_lo5 = '0;
    logic [2:0]      imm_hi3 = '0;
    logic            tbl_from_reg = 1'b0, mask_en = 1'b0;
    logic [3:0]      lane_mask = '0;
    logic            out_valid;
    logic [XLEN-1:0] result;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    item_t sb_q[$];

    always #10 clk = ~clk;

    tlu_top #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .imm_lo5(imm_lo5), .imm_hi3(imm_hi3), .tbl_reg(tbl_reg),
        .tbl_from_reg(tbl_from_reg), .mask_en(mask_en), .lane_mask(lane_mask),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [XLEN-1:0] ref_model(
        input logic [XLEN-1:0] t, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
        input logic [7:0] tbl, input logic men, input logic [3:0] msk);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) begin
            int k;
            k = 4 * int'(t[i]) + 2 * int'(a[i]) + int'(b[i]);
            r[i] = tbl[k];
        end
        if (men) begin
            for (int j = 0; j < XLEN / 8; j++) begin
                if (!(j < 4 && msk[j])) r[8*j +: 8] = t[8*j +: 8];
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [XLEN-1:0] t, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b, input logic [7:0] imm, input logic [XLEN-1:0] treg,
                         input logic from_reg, input logic men, input logic [3:0] msk,
                         input logic [XLEN-1:0] exp);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; old_dst = t; src_a = a; src_b = b;
        imm_lo5 = imm[4:0]; imm_hi3 = imm[7:5]; tbl_reg = treg;
        tbl_from_reg = from_reg; mask_en = men; lane_mask = msk;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops one expected item per valid result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check("R2 spurious valid", 64'h1, 64'h0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, result, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] t0, a0, b0, junk;
        t0 = 64'hF0F0_1234_A5A5_0FF0;
        a0 = 64'hCCCC_5678_3C3C_00FF;
        b0 = 64'hAAAA_9ABC_6969_FFFF;
        junk = 64'hDEAD_BEEF_CAFE_0000;

        repeat (3) @(negedge clk);
        check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 result in reset", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {63'd0, out_valid}, 64'd0);
        check("R1 result after reset", result, 64'd0);

        // R9 / R3 / R4 named functions, immediate table split across two fields
        drive("R9 xor 0x96", t0, a0, b0, 8'h96, junk, 1'b0, 1'b0, 4'h0, t0 ^ a0 ^ b0);
        drive("R9 majority 0xE8", t0, a0, b0, 8'hE8, junk, 1'b0, 1'b0, 4'h0,
              (t0 & a0) | (t0 & b0) | (a0 & b0));
        drive("R9 pass dst 0xF0", t0, a0, b0, 8'hF0, junk, 1'b0, 1'b0, 4'h0, t0);
        drive("R3 select a 0xCC", t0, a0, b0, 8'hCC, junk, 1'b0, 1'b0, 4'h0, a0);
        drive("R3 select b 0xAA", t0, a0, b0, 8'hAA, junk, 1'b0, 1'b0, 4'h0, b0);
        drive("R3 index0 only 0x01", t0, a0, b0, 8'h01, junk, 1'b0, 1'b0, 4'h0, ~(t0 | a0 | b0));
        drive("R4 high field only 0x80", t0, a0, b0, 8'h80, junk, 1'b0, 1'b0, 4'h0, t0 & a0 & b0);
        drive("R4 low field 0x1F", t0, a0, b0, 8'h1F, junk, 1'b0, 1'b0, 4'h0,
              ref_model(t0, a0, b0, 8'h1F, 1'b0, 4'h0));
        // R8: lane_mask ignored when masking is off
        drive("R8 mask ignored", t0, a0, b0, 8'h96, junk, 1'b0, 1'b0, 4'h5, t0 ^ a0 ^ b0);
        // R5: register table with junk upper bits and immediate set to something else
        drive("R5 reg table 0xE8", t0, a0, b0, 8'h00, {56'hFFEE_DDCC_BBAA_99, 8'hE8}, 1'b1, 1'b0, 4'h0,
              (t0 & a0) | (t0 & b0) | (a0 & b0));
        drive("R5 reg table zero", t0, a0, b0, 8'hFF, {56'h1234_5678_9ABC_DE, 8'h00}, 1'b1, 1'b0, 4'h0, 64'd0);
        // R6 / R7: lane masking
        drive("R6 lanes 0 and 2", t0, a0, b0, 8'h96, junk, 1'b0, 1'b1, 4'b0101,
              ref_model(t0, a0, b0, 8'h96, 1'b1, 4'b0101));
        drive("R7 no lanes", t0, a0, b0, 8'h96, junk, 1'b0, 1'b1, 4'b0000, t0);
        drive("R7 upper lanes kept", t0, a0, b0, 8'h00, junk, 1'b0, 1'b1, 4'b1111, {t0[63:32], 32'd0});
        // R6 + R5 together: register table with masking and junk elsewhere
        drive("R6 R5 masked reg table", t0, a0, b0, 8'h00, {56'hA5A5_A5A5_A5A5_A5, 8'hCC}, 1'b1, 1'b1, 4'b1010,
              {t0[63:32], a0[31:24], t0[23:16], a0[15:8], t0[7:0]});
        idle();
        @(negedge clk);
        check("R2 valid low after idle", {63'd0, out_valid}, 64'd0);
        check("R10 hold after idle", result, {t0[63:32], a0[31:24], t0[23:16], a0[15:8], t0[7:0]});
        @(negedge clk);
        check("R10 hold second idle", result, {t0[63:32], a0[31:24], t0[23:16], a0[15:8], t0[7:0]});

        // sweep single-bit tables over all eight index patterns
        for (int k = 0; k < 8; k++) begin
            logic [7:0] tb;
            tb = 8'h01 << k;
            drive("R3 minterm sweep", 64'hFFFF_FFFF_0000_0000, 64'hFFFF_0000_FFFF_0000,
                  64'hFF00_FF00_FF00_FF00, tb, junk, 1'b0, 1'b0, 4'h0,
                  {{8{tb[7]}}, {8{tb[6]}}, {8{tb[5]}}, {8{tb[4]}},
                   {8{tb[3]}}, {8{tb[2]}}, {8{tb[1]}}, {8{tb[0]}}});
        end
        idle();
        repeat (3) @(negedge clk);
        check("R2 all results returned", 64'(sb_q.size()), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule